// File: doc/BRIEF.md
# Prioritized Interrupt Selector

This block watches a parameterised set of interrupt lines and, every cycle, picks the one pending request that may reach the CPU. That request is presented on a registered output as an ID, its stored priority and a valid flag. Each interrupt ID keeps its own configuration: an 8-bit priority in which smaller means more urgent, a group code, a trigger type (edge or level), an enable bit and a non-maskable flag. Configuration is written one ID at a time through a write port. Enables are changed through separate set and clear mask ports, so software never has to read, modify and write them back.

A request qualifies only when all of the following hold: it is pending, it is enabled, both the global distribution enable and the CPU-side signalling enable of its group are on, and its priority value is strictly below the priority mask. A balanced comparison tree then chooses among the qualifying requests. Edge-type IDs hold a pending latch that an acknowledge clears. The lowest IDs are reserved for software-generated interrupts and are always edge-type. A combinational readback port returns the stored configuration of any ID.

Top module: `prio_irq_select`

## Requirements
- R1: After reset, selValid is 0, selId is all ones and selPrio is 0xFF. Every enable, pending latch, priority, group and non-maskable flag is 0. Trigger type reads 1 for IDs below NUM_SGI and 0 for the others.
- R2: Only the top PRIO_BITS bits of a written priority are kept. The lower bits read back as zero and take part in comparison as zero.
- R3: Among qualifying requests, the smallest effective priority value wins. Ties go to the lowest ID. The result appears on the registered selection outputs.
- R4: A request qualifies only if its stored priority is strictly less than prioMask. A priority equal to the mask is blocked.
- R5: Group codes are 0 (group zero), 1 (secure group one) and 2 (non-secure group one). A written code of 3 is stored as 2. A request qualifies only if both distEn[code] and cpuEn[code] are 1.
- R6: When setEnWe is high, each 1 in setEnMask sets that ID's enable. When clrEnWe is high, each 1 in clrEnMask clears it. If both ports hit the same ID in the same cycle, the clear wins.
- R7: IDs below NUM_SGI always read trigger type 1 (edge), whatever value is written.
- R8: A non-maskable request outranks every request that is not non-maskable. It still obeys the priority mask and the enables. A non-maskable flag written together with group code 0 is stored as 0.
- R9: An edge-type ID latches pending on a rising input edge. The latch stays set after the input falls and is cleared by ackValid with a matching ackId.
- R10: A level-type ID is pending exactly while its input is high.
- R11: When no request qualifies, selValid is 0, selId is all ones and selPrio is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgId | input | ID_W | ID being configured |
| cfgPrio | input | 8 | Priority value, 0x00 is most urgent |
| cfgGroup | input | 2 | Group code (0, 1, 2) |
| cfgTrigEdge | input | 1 | 1 selects edge type, 0 selects level type |
| cfgNmi | input | 1 | Non-maskable flag |
| setEnWe | input | 1 | Set-enable strobe |
| setEnMask | input | NUM_IDS | IDs to enable |
| clrEnWe | input | 1 | Clear-enable strobe |
| clrEnMask | input | NUM_IDS | IDs to disable |
| ackValid | input | 1 | Acknowledge strobe |
| ackId | input | ID_W | ID whose edge latch is cleared |
| irqIn | input | NUM_IDS | Interrupt request lines |
| distEn | input | 3 | Global distribution enable, one bit per group |
| cpuEn | input | 3 | CPU-side signalling enable, one bit per group |
| prioMask | input | 8 | Priority mask threshold |
| rdId | input | ID_W | ID selected for readback |
| rdPrio | output | 8 | Stored priority of rdId |
| rdGroup | output | 2 | Stored group of rdId |
| rdTrigEdge | output | 1 | Stored trigger type of rdId |
| rdNmi | output | 1 | Stored non-maskable flag of rdId |
| rdEnable | output | 1 | Enable bit of rdId |
| rdPending | output | 1 | Pending state of rdId |
| selValid | output | 1 | A request is selected |
| selId | output | ID_W | Selected ID, or all ones when none |
| selPrio | output | 8 | Priority of the selected ID, or 0xFF when none |

## Verification
The assertions check the following on every cycle:
- a valid selection never carries a priority at or above the mask of the previous cycle;
- the idle output always shows the all-ones code;
- truncated priority bits, software-generated trigger types and the non-maskable group restriction hold on the readback port;
- a selected ID always lies in range.

Only the bench scenarios can show which request wins. These scenarios cover tie breaking by ID, non-maskable promotion, the interaction of the two enable layers, set-versus-clear ordering, and an edge latch that outlives its input pulse until it is acknowledged.

// File: rtl/pir_pkg.sv
package pir_pkg;
  typedef enum logic [1:0] {
    GRP_ZERO     = 2'd0,
    GRP_ONE_SEC  = 2'd1,
    GRP_ONE_NSEC = 2'd2
  } grp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgWr;
    logic setEn;
    logic clrEn;
    logic ack;
  } strobe_t;

  // sanitised configuration fields
  typedef struct packed {
    logic [7:0] prio;
    logic [1:0] grp;
    logic       trigEdge;
    logic       nmi;
  } cfg_t;
endpackage

// File: rtl/pir_ctrl.sv
module pir_ctrl
  import pir_pkg::*;
#(
  parameter int NUM_IDS   = 16,
  parameter int NUM_SGI   = 4,
  parameter int PRIO_BITS = 5,
  parameter int ID_W      = $clog2(NUM_IDS + 1)
) (
  input  logic            cfgWe,
  input  logic [ID_W-1:0] cfgId,
  input  logic [7:0]      cfgPrio,
  input  logic [1:0]      cfgGroup,
  input  logic            cfgTrigEdge,
  input  logic            cfgNmi,
  input  logic            setEnWe,
  input  logic            clrEnWe,
  input  logic            ackValid,
  input  logic [ID_W-1:0] ackId,
  output strobe_t         stb,
  output cfg_t            cfgOut
);
  localparam logic [7:0]      KEEP_MASK = 8'hFF << (8 - PRIO_BITS);
  localparam logic [ID_W-1:0] ID_LIMIT  = ID_W'(NUM_IDS);
  localparam logic [ID_W-1:0] SGI_LIMIT = ID_W'(NUM_SGI);

  logic [1:0] grpFold;

  always_comb begin
    grpFold         = (cfgGroup == 2'd3) ? GRP_ONE_NSEC : cfgGroup;
    cfgOut.prio     = cfgPrio & KEEP_MASK;
    cfgOut.grp      = grpFold;
    cfgOut.trigEdge = cfgTrigEdge || (cfgId < SGI_LIMIT);
    cfgOut.nmi      = cfgNmi && (grpFold != GRP_ZERO);
    stb.cfgWr       = cfgWe && (cfgId < ID_LIMIT);
    stb.setEn       = setEnWe;
    stb.clrEn       = clrEnWe;
    stb.ack         = ackValid && (ackId < ID_LIMIT);
  end
endmodule

// File: rtl/pir_datapath.sv
module pir_datapath
  import pir_pkg::*;
#(
  parameter int NUM_IDS   = 16,
  parameter int NUM_SGI   = 4,
  parameter int ID_W      = $clog2(NUM_IDS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  cfg_t               cfgIn,
  input  logic [ID_W-1:0]    cfgId,
  input  logic [ID_W-1:0]    ackId,
  input  logic [NUM_IDS-1:0] setEnMask,
  input  logic [NUM_IDS-1:0] clrEnMask,
  input  logic [NUM_IDS-1:0] irqIn,
  input  logic [2:0]         distEn,
  input  logic [2:0]         cpuEn,
  input  logic [7:0]         prioMask,
  input  logic [ID_W-1:0]    rdId,
  output logic [7:0]         rdPrio,
  output logic [1:0]         rdGroup,
  output logic               rdTrigEdge,
  output logic               rdNmi,
  output logic               rdEnable,
  output logic               rdPending,
  output logic               selValid,
  output logic [ID_W-1:0]    selId,
  output logic [7:0]         selPrio
);
  localparam int LVL   = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
  localparam int PAD   = 1 << LVL;
  localparam int IDX_W = LVL;
  localparam logic [ID_W-1:0] NONE_ID  = '1;
  localparam logic [ID_W-1:0] ID_LIMIT = ID_W'(NUM_IDS);

  logic [7:0]         prioQ [NUM_IDS];
  logic [1:0]         grpQ  [NUM_IDS];
  logic [NUM_IDS-1:0] edgeQ, nmiQ, enQ, pendQ, prevQ;
  logic [NUM_IDS-1:0] active;

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_IDS; k++) begin
      if (rst) begin
        prioQ[k] <= '0;
        grpQ[k]  <= '0;
        edgeQ[k] <= (k < NUM_SGI);
        nmiQ[k]  <= 1'b0;
        enQ[k]   <= 1'b0;
        pendQ[k] <= 1'b0;
        prevQ[k] <= 1'b0;
      end else begin
        if (stb.cfgWr && cfgId == ID_W'(k)) begin
          prioQ[k] <= cfgIn.prio;
          grpQ[k]  <= cfgIn.grp;
          edgeQ[k] <= cfgIn.trigEdge;
          nmiQ[k]  <= cfgIn.nmi;
        end
        if (stb.clrEn && clrEnMask[k])      enQ[k] <= 1'b0;
        else if (stb.setEn && setEnMask[k]) enQ[k] <= 1'b1;
        prevQ[k] <= irqIn[k];
        if (irqIn[k] && !prevQ[k])                pendQ[k] <= 1'b1;
        else if (stb.ack && ackId == ID_W'(k))    pendQ[k] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_IDS; k++) begin
      active[k] = (edgeQ[k] ? pendQ[k] : irqIn[k]) && enQ[k] &&
                  distEn[grpQ[k]] && cpuEn[grpQ[k]] && (prioQ[k] < prioMask);
    end
  end

  // comparison tree: node n has children 2n and 2n+1, leaves at PAD..2*PAD-1
  logic [2*PAD-1:1]           nodeV;
  logic [2*PAD-1:1][8:0]      nodeK;
  logic [2*PAD-1:1][ID_W-1:0] nodeI;

  for (genvar j = 0; j < PAD; j++) begin : g_leaf
    if (j < NUM_IDS) begin : g_real
      assign nodeV[PAD+j] = active[j];
      assign nodeK[PAD+j] = {nmiQ[j], ~prioQ[j]};
      assign nodeI[PAD+j] = ID_W'(j);
    end else begin : g_pad
      assign nodeV[PAD+j] = 1'b0;
      assign nodeK[PAD+j] = '0;
      assign nodeI[PAD+j] = NONE_ID;
    end
  end

  for (genvar n = 1; n < PAD; n++) begin : g_node
    logic takeL;
    assign takeL    = nodeV[2*n] && (!nodeV[2*n+1] || nodeK[2*n] >= nodeK[2*n+1]);
    assign nodeV[n] = nodeV[2*n] || nodeV[2*n+1];
    assign nodeK[n] = takeL ? nodeK[2*n] : nodeK[2*n+1];
    assign nodeI[n] = takeL ? nodeI[2*n] : nodeI[2*n+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      selValid <= 1'b0;
      selId    <= NONE_ID;
      selPrio  <= 8'hFF;
    end else begin
      selValid <= nodeV[1];
      selId    <= nodeV[1] ? nodeI[1] : NONE_ID;
      selPrio  <= nodeV[1] ? ~nodeK[1][7:0] : 8'hFF;
    end
  end

  logic [IDX_W-1:0] rdIdx;
  logic             rdOk;
  assign rdIdx = rdId[IDX_W-1:0];
  assign rdOk  = rdId < ID_LIMIT;

  always_comb begin
    rdPrio     = rdOk ? prioQ[rdIdx] : 8'h00;
    rdGroup    = rdOk ? grpQ[rdIdx]  : 2'd0;
    rdTrigEdge = rdOk && edgeQ[rdIdx];
    rdNmi      = rdOk && nmiQ[rdIdx];
    rdEnable   = rdOk && enQ[rdIdx];
    rdPending  = rdOk && (edgeQ[rdIdx] ? pendQ[rdIdx] : irqIn[rdIdx]);
  end
endmodule

// File: rtl/prio_irq_select.sv
module prio_irq_select
  import pir_pkg::*;
#(
  parameter int NUM_IDS   = 16,
  parameter int NUM_SGI   = 4,
  parameter int PRIO_BITS = 5,
  parameter int ID_W      = $clog2(NUM_IDS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWe,
  input  logic [ID_W-1:0]    cfgId,
  input  logic [7:0]         cfgPrio,
  input  logic [1:0]         cfgGroup,
  input  logic               cfgTrigEdge,
  input  logic               cfgNmi,
  input  logic               setEnWe,
  input  logic [NUM_IDS-1:0] setEnMask,
  input  logic               clrEnWe,
  input  logic [NUM_IDS-1:0] clrEnMask,
  input  logic               ackValid,
  input  logic [ID_W-1:0]    ackId,
  input  logic [NUM_IDS-1:0] irqIn,
  input  logic [2:0]         distEn,
  input  logic [2:0]         cpuEn,
  input  logic [7:0]         prioMask,
  input  logic [ID_W-1:0]    rdId,
  output logic [7:0]         rdPrio,
  output logic [1:0]         rdGroup,
  output logic               rdTrigEdge,
  output logic               rdNmi,
  output logic               rdEnable,
  output logic               rdPending,
  output logic               selValid,
  output logic [ID_W-1:0]    selId,
  output logic [7:0]         selPrio
);
  strobe_t stb;
  cfg_t    cfgSan;

  pir_ctrl #(.NUM_IDS(NUM_IDS), .NUM_SGI(NUM_SGI), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_ctrl (
    .cfgWe(cfgWe), .cfgId(cfgId), .cfgPrio(cfgPrio), .cfgGroup(cfgGroup),
    .cfgTrigEdge(cfgTrigEdge), .cfgNmi(cfgNmi), .setEnWe(setEnWe), .clrEnWe(clrEnWe),
    .ackValid(ackValid), .ackId(ackId), .stb(stb), .cfgOut(cfgSan)
  );

  pir_datapath #(.NUM_IDS(NUM_IDS), .NUM_SGI(NUM_SGI), .ID_W(ID_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .cfgIn(cfgSan), .cfgId(cfgId), .ackId(ackId),
    .setEnMask(setEnMask), .clrEnMask(clrEnMask), .irqIn(irqIn),
    .distEn(distEn), .cpuEn(cpuEn), .prioMask(prioMask), .rdId(rdId),
    .rdPrio(rdPrio), .rdGroup(rdGroup), .rdTrigEdge(rdTrigEdge), .rdNmi(rdNmi),
    .rdEnable(rdEnable), .rdPending(rdPending),
    .selValid(selValid), .selId(selId), .selPrio(selPrio)
  );
endmodule

// File: rtl/pir_checker.sv
module pir_checker #(
  parameter int NUM_IDS   = 16,
  parameter int NUM_SGI   = 4,
  parameter int PRIO_BITS = 5,
  parameter int ID_W      = $clog2(NUM_IDS + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic [7:0]      prioMask,
  input logic [ID_W-1:0] rdId,
  input logic [7:0]      rdPrio,
  input logic [1:0]      rdGroup,
  input logic            rdTrigEdge,
  input logic            rdNmi,
  input logic            selValid,
  input logic [ID_W-1:0] selId,
  input logic [7:0]      selPrio
);
  localparam logic [7:0]      LOW_MASK = ~(8'hFF << (8 - PRIO_BITS));
  localparam logic [ID_W-1:0] ID_LIMIT  = ID_W'(NUM_IDS);
  localparam logic [ID_W-1:0] SGI_LIMIT = ID_W'(NUM_SGI);

  a_r4_below_mask: assert property (@(posedge clk) disable iff (rst)
    selValid |-> selPrio < $past(prioMask));

  a_r11_idle_code: assert property (@(posedge clk) disable iff (rst)
    !selValid |-> (selId == '1 && selPrio == 8'hFF));

  a_r3_id_in_range: assert property (@(posedge clk) disable iff (rst)
    selValid |-> selId < ID_LIMIT);

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (rdPrio & LOW_MASK) == 8'h00);

  a_r7_sgi_edge: assert property (@(posedge clk) disable iff (rst)
    rdId < SGI_LIMIT |-> rdTrigEdge);

  a_r8_nmi_group_one: assert property (@(posedge clk) disable iff (rst)
    rdNmi |-> rdGroup != 2'd0);
endmodule

bind prio_irq_select pir_checker #(
  .NUM_IDS(NUM_IDS), .NUM_SGI(NUM_SGI), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)
) u_pir_checker (
  .clk(clk), .rst(rst), .prioMask(prioMask), .rdId(rdId), .rdPrio(rdPrio),
  .rdGroup(rdGroup), .rdTrigEdge(rdTrigEdge), .rdNmi(rdNmi),
  .selValid(selValid), .selId(selId), .selPrio(selPrio)
);

// File: tb/test_prio_irq_select.sv
`timescale 1ns/1ps
module test_prio_irq_select;
  localparam int N = 16;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWe = 0, cfgTrigEdge = 0, cfgNmi = 0;
  logic [W-1:0] cfgId = '0, ackId = '0, rdId = '0;
  logic [7:0] cfgPrio = '0, prioMask = 8'hFF;
  logic [1:0] cfgGroup = '0;
  logic setEnWe = 0, clrEnWe = 0, ackValid = 0;
  logic [N-1:0] setEnMask = '0, clrEnMask = '0, irqIn = '0;
  logic [2:0] distEn = 3'b111, cpuEn = 3'b111;
  logic [7:0] rdPrio, selPrio;
  logic [1:0] rdGroup;
  logic rdTrigEdge, rdNmi, rdEnable, rdPending, selValid;
  logic [W-1:0] selId;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  prio_irq_select i_prio_irq_select (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgId(cfgId), .cfgPrio(cfgPrio),
    .cfgGroup(cfgGroup), .cfgTrigEdge(cfgTrigEdge), .cfgNmi(cfgNmi),
    .setEnWe(setEnWe), .setEnMask(setEnMask), .clrEnWe(clrEnWe), .clrEnMask(clrEnMask),
    .ackValid(ackValid), .ackId(ackId), .irqIn(irqIn), .distEn(distEn), .cpuEn(cpuEn),
    .prioMask(prioMask), .rdId(rdId), .rdPrio(rdPrio), .rdGroup(rdGroup),
    .rdTrigEdge(rdTrigEdge), .rdNmi(rdNmi), .rdEnable(rdEnable), .rdPending(rdPending),
    .selValid(selValid), .selId(selId), .selPrio(selPrio)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkSel(input string req, input logic v, input int id, input int pr);
    check({req, " valid"}, selValid, v);
    check({req, " id"}, selId, id);
    check({req, " prio"}, selPrio, pr);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input int id, input int pr, input int g, input logic e, input logic nm);
    @(negedge clk);
    cfgWe = 1; cfgId = W'(id); cfgPrio = 8'(pr); cfgGroup = 2'(g);
    cfgTrigEdge = e; cfgNmi = nm;
    @(negedge clk);
    cfgWe = 0;
  endtask

  // {irqIn, prioMask, expValid, expId, expPrio}
  localparam logic [37:0] VEC [12] = '{
    {16'h0010, 8'hFF, 1'b1, 5'd4,  8'h40},
    {16'h0030, 8'hFF, 1'b1, 5'd4,  8'h40},
    {16'h0020, 8'hFF, 1'b1, 5'd5,  8'h40},
    {16'h0050, 8'hFF, 1'b1, 5'd6,  8'h20},
    {16'h0250, 8'hFF, 1'b1, 5'd9,  8'h10},
    {16'h0350, 8'hFF, 1'b1, 5'd8,  8'hC0},
    {16'h0080, 8'hFF, 1'b1, 5'd7,  8'h80},
    {16'h0080, 8'h80, 1'b0, 5'd31, 8'hFF},
    {16'h0080, 8'h81, 1'b1, 5'd7,  8'h80},
    {16'h0050, 8'h30, 1'b1, 5'd6,  8'h20},
    {16'h0100, 8'hC0, 1'b0, 5'd31, 8'hFF},
    {16'h0000, 8'hFF, 1'b0, 5'd31, 8'hFF}
  };

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    checkSel("R1", 0, 31, 8'hFF);
    rdId = 5'd4;
    #1 check("R1 enable", rdEnable, 0);
    check("R1 trig non-sgi", rdTrigEdge, 0);
    rdId = 5'd2;
    #1 check("R1 trig sgi", rdTrigEdge, 1);

    cfg(1, 8'h30, 0, 0, 0);
    cfg(4, 8'h40, 2, 0, 0);
    cfg(5, 8'h40, 2, 0, 0);
    cfg(6, 8'h20, 0, 0, 0);
    cfg(7, 8'h87, 1, 0, 0);
    cfg(8, 8'hC0, 3, 0, 1);
    cfg(9, 8'h10, 0, 0, 1);
    cfg(10, 8'h50, 1, 1, 0);
    @(negedge clk);
    setEnWe = 1; setEnMask = 16'h07F2;
    @(negedge clk);
    setEnWe = 0;

    rdId = 5'd7;
    #1 check("R2 truncated prio", rdPrio, 8'h80);
    check("R5 group sec", rdGroup, 1);
    rdId = 5'd1;
    #1 check("R7 sgi trig forced", rdTrigEdge, 1);
    rdId = 5'd8;
    #1 check("R5 code3 folds to 2", rdGroup, 2);
    check("R8 nmi kept group1", rdNmi, 1);
    rdId = 5'd9;
    #1 check("R8 nmi dropped group0", rdNmi, 0);

    // R3 R4 R8 R10 R11 table
    foreach (VEC[i]) begin
      irqIn = VEC[i][37:22];
      prioMask = VEC[i][21:14];
      settle();
      checkSel($sformatf("R3/R4/R8/R10/R11 vec%0d", i), VEC[i][13], int'(VEC[i][12:8]), int'(VEC[i][7:0]));
    end
    prioMask = 8'hFF;

    // R5 group enable layers
    irqIn = 16'h0050; distEn = 3'b110;
    settle();
    checkSel("R5 dist off grp0", 1, 4, 8'h40);
    irqIn = 16'h0090; distEn = 3'b111; cpuEn = 3'b011;
    settle();
    checkSel("R5 cpu off grp nsec", 1, 7, 8'h80);
    cpuEn = 3'b111;

    // R6 set/clear enables
    irqIn = 16'h0010;
    clrEnWe = 1; clrEnMask = 16'h0010;
    @(negedge clk);
    clrEnWe = 0;
    settle();
    checkSel("R6 cleared id ignored", 0, 31, 8'hFF);
    rdId = 5'd5;
    setEnWe = 1; setEnMask = 16'h0020; clrEnWe = 1; clrEnMask = 16'h0020;
    @(negedge clk);
    setEnWe = 0; clrEnWe = 0;
    #1 check("R6 clear wins", rdEnable, 0);
    irqIn = '0;

    // R9 edge latch and acknowledge
    settle();
    irqIn = 16'h0400;
    @(negedge clk);
    irqIn = '0;
    settle();
    checkSel("R9 edge held", 1, 10, 8'h50);
    rdId = 5'd10;
    #1 check("R9 pending readback", rdPending, 1);
    ackValid = 1; ackId = 5'd10;
    @(negedge clk);
    ackValid = 0;
    settle();
    checkSel("R9 acked", 0, 31, 8'hFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule